// File: doc/BRIEF.md
# Serial Port with Framing-Error Flag

This block is a byte-oriented serial port with four operating modes. There is a synchronous shift mode, an asynchronous 8-bit mode and two asynchronous 9-bit modes. Software drives it through a small register port:

- a control/status register holding the mode, receive enable, address-filter enable, ninth-bit values and the two interrupt flags;
- a data register, where a write starts a transmission and a read returns the last accepted byte;
- an option register.

Bit rate comes from an external strobe `baud_tick`. In the asynchronous modes one bit lasts `OSR` strobes. In the shift mode each bit lasts two strobes: the shift clock is low for one strobe and high for the next.

The top bit of the control register has two meanings that are stored apart. With the view-select option bit at 0 it is the high mode bit. With the option bit at 1 it is a sticky framing-error flag. The receiver raises the flag on every frame whose stop bit samples low, whatever the view setting. The flag is set without touching the stored mode, and only a software write of 0 clears it. A single `irq` output reports either pending interrupt flag.

Top module: `sio_fe_uart`

## Requirements
- R1: After reset the control register reads 00h, the data and option registers read 00h, `txd` and `shift_clk` are high, and `irq` is low.
- R2: Register addresses are 0 (control), 1 (data) and 2 (option, bit 0 = view select). Control bits are [7] mode-high or error flag, [6] mode-low, [5] filter enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] TI, [0] RI. With view 0, bit 7 reads and writes the mode-high bit. With view 1, it reads and writes the error flag. The two values are held separately.
- R3: A received asynchronous frame whose stop bit votes low sets the error flag, whatever the view bit or the RI state. The stored mode is unchanged.
- R4: The error flag stays set through later valid frames. Only a control write with view 1 and bit 7 = 0 clears it.
- R5: Mode 01 transmits a low start bit, 8 data bits LSB first and a high stop bit, each `OSR` strobes long. TI rises at the start of the stop bit.
- R6: In modes 10 and 11 the transmitted ninth bit comes from control bit 3 and the received ninth bit is stored in bit 2. In mode 01 the received stop bit is stored in bit 2.
- R7: The receiver starts on a falling edge of `rxd` and takes each bit as the majority of three samples around mid-bit. A start bit that votes high aborts the reception without effect.
- R8: When an asynchronous frame completes with RI clear, the data register takes the byte and RI rises. When RI is still set, the frame is discarded and the data register keeps its value.
- R9: With filter enable set, a 9-bit-mode frame is accepted only if its ninth bit is 1, and a mode-01 frame only if its stop bit is valid.
- R10: Mode 00 transmits 8 bits LSB first on `shift_dout`. Each bit is valid across one low and one high phase of `shift_clk`, and TI rises after the eighth bit.
- R11: In mode 00, with receive enable set and RI clear, the block clocks in 8 bits LSB first from `rxd` at the end of each high phase of `shift_clk`. RI rises after the eighth bit.
- R12: TI and RI stay set until software writes 0 to them. `irq` is high exactly while TI or RI is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Bit-rate strobe (oversample rate in async modes) |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write enable |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Asynchronous transmit line, idle high |
| shift_dout | output | 1 | Shift-mode transmit data |
| shift_clk | output | 1 | Shift-mode clock, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OSR` = 8 and toggles `baud_tick` so that it is high every other clock. One asynchronous bit then lasts 16 clocks and one shift-mode bit lasts 4 clocks. This keeps whole 9-bit frames, false-start pulses, discarded frames and filter rejections short enough to run many frames in sequence. The majority-vote window (samples 3, 4, 5) stays well inside each bit despite the two-flop input synchronizer.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_DAT = 2'd1;
  localparam logic [1:0] ADDR_OPT = 2'd2;

  localparam logic [1:0] MODE_SHIFT = 2'b00;

  // Majority of three line samples.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Bit index of the stop bit in an async frame (start bit = index 0).
  function automatic logic [3:0] stop_idx(input logic [1:0] m);
    return m[1] ? 4'd10 : 4'd9;
  endfunction

  // True when the async frame carries a ninth data bit.
  function automatic logic has_ninth(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       tb8,
  output logic       txd,
  output logic       sdat_o,
  output logic       sclk_o,
  output logic       busy,
  output logic       done_evt
);
  import sio_pkg::*;
  localparam int CW = $clog2(OSR);

  logic [CW-1:0] tcnt;
  logic [3:0]    idx;
  logic [9:0]    sh;
  logic          ph;
  logic          is_sync;
  logic [3:0]    last_idx;
  logic          bit_end;

  assign is_sync  = (mode == MODE_SHIFT);
  assign last_idx = stop_idx(mode);
  assign bit_end  = busy && tick && (is_sync ? ph : (tcnt == CW'(OSR - 1)));
  // Shift mode: end of eighth bit. Async: entering the stop bit.
  assign done_evt = bit_end && (is_sync ? (idx == 4'd7) : ((idx + 4'd1) == last_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      txd    <= 1'b1;
      sdat_o <= 1'b1;
      sclk_o <= 1'b1;
      tcnt   <= '0;
      idx    <= '0;
      sh     <= '1;
      ph     <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      tcnt <= '0;
      idx  <= '0;
      ph   <= 1'b0;
      if (is_sync) begin
        sdat_o <= din[0];
        sclk_o <= 1'b0;
        sh     <= {3'b111, din[7:1]};
      end else begin
        txd <= 1'b0;
        sh  <= has_ninth(mode) ? {1'b1, tb8, din} : {2'b11, din};
      end
    end else if (busy && tick) begin
      if (is_sync) begin
        if (!ph) begin
          ph     <= 1'b1;
          sclk_o <= 1'b1;
        end else begin
          ph <= 1'b0;
          if (idx == 4'd7) begin
            busy   <= 1'b0;
            sdat_o <= 1'b1;
          end else begin
            idx    <= idx + 4'd1;
            sdat_o <= sh[0];
            sh     <= {1'b1, sh[9:1]};
            sclk_o <= 1'b0;
          end
        end
      end else begin
        if (tcnt == CW'(OSR - 1)) begin
          tcnt <= '0;
          if (idx == last_idx) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            idx <= idx + 4'd1;
            txd <= sh[0];
            sh  <= {1'b1, sh[9:1]};
          end
        end else begin
          tcnt <= tcnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       ren,
  input  logic       ri,
  input  logic       sm2,
  input  logic       rxd,
  output logic       sclk_o,
  output logic       stop_bad,
  output logic       accept,
  output logic [7:0] data,
  output logic       rb8_val
);
  import sio_pkg::*;
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic          rx_m, rx_s, rx_d;
  logic          a_act;
  logic [CW-1:0] tcnt;
  logic [3:0]    idx;
  logic          s0, s1;
  logic [8:0]    sh;
  logic          s_act, ph;
  logic [2:0]    sidx;

  logic       is_sync, nine, vote, vote_evt, a_stop_evt, s_done, frame_evt, filt_ok;
  logic [3:0] last_idx;

  assign is_sync    = (mode == MODE_SHIFT);
  assign nine       = has_ninth(mode);
  assign last_idx   = stop_idx(mode);
  assign vote       = vote3(s0, s1, rx_s);
  assign vote_evt   = a_act && tick && (tcnt == CW'(MID + 1));
  assign a_stop_evt = vote_evt && (idx == last_idx);
  assign s_done     = s_act && tick && ph && (sidx == 3'd7);
  assign frame_evt  = a_stop_evt || s_done;
  assign stop_bad   = a_stop_evt && !vote;
  assign rb8_val    = nine ? sh[8] : vote;
  assign data       = is_sync ? {rx_s, sh[8:2]} : (nine ? sh[7:0] : sh[8:1]);
  assign filt_ok    = is_sync || !sm2 || (nine ? sh[8] : vote);
  assign accept     = frame_evt && !ri && filt_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m   <= 1'b1;
      rx_s   <= 1'b1;
      rx_d   <= 1'b1;
      a_act  <= 1'b0;
      tcnt   <= '0;
      idx    <= '0;
      s0     <= 1'b1;
      s1     <= 1'b1;
      sh     <= '0;
      s_act  <= 1'b0;
      ph     <= 1'b0;
      sidx   <= '0;
      sclk_o <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_d <= rx_s;
      // asynchronous receiver
      if (!a_act) begin
        if (!is_sync && ren && rx_d && !rx_s) begin
          a_act <= 1'b1;
          tcnt  <= '0;
          idx   <= '0;
        end
      end else if (tick) begin
        if (tcnt == CW'(MID - 1)) s0 <= rx_s;
        if (tcnt == CW'(MID))     s1 <= rx_s;
        if (vote_evt) begin
          if (idx == 4'd0) begin
            if (vote) a_act <= 1'b0;
          end else if (idx == last_idx) begin
            a_act <= 1'b0;
          end else begin
            sh <= {vote, sh[8:1]};
          end
        end
        if (tcnt == CW'(OSR - 1)) begin
          tcnt <= '0;
          idx  <= idx + 4'd1;
        end else begin
          tcnt <= tcnt + CW'(1);
        end
      end
      // synchronous shift receiver
      if (!s_act) begin
        sclk_o <= 1'b1;
        if (is_sync && ren && !ri) begin
          s_act  <= 1'b1;
          ph     <= 1'b0;
          sidx   <= '0;
          sclk_o <= 1'b0;
        end
      end else if (tick) begin
        if (!ph) begin
          ph     <= 1'b1;
          sclk_o <= 1'b1;
        end else begin
          ph <= 1'b0;
          sh <= {rx_s, sh[8:1]};
          if (sidx == 3'd7) begin
            s_act  <= 1'b0;
            sclk_o <= 1'b1;
          end else begin
            sidx   <= sidx + 3'd1;
            sclk_o <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_fe_uart.sv
module sio_fe_uart #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       shift_dout,
  output logic       shift_clk,
  output logic       irq
);
  import sio_pkg::*;

  logic       sm0, fe, sm1, sm2, ren, tb8, rb8, ti, ri, fe_view;
  logic [7:0] rbuf;
  logic [1:0] mode;
  logic       ctl_wr, dat_wr, opt_wr;
  logic [7:0] ctl_rd;

  logic       tx_busy, tx_done_evt, tx_sclk, rx_sclk;
  logic       rx_stop_bad, rx_accept, rx_rb8;
  logic [7:0] rx_data;

  assign mode   = {sm0, sm1};
  assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);
  assign dat_wr = bus_wr && (bus_addr == ADDR_DAT);
  assign opt_wr = bus_wr && (bus_addr == ADDR_OPT);
  assign ctl_rd = {(fe_view ? fe : sm0), sm1, sm2, ren, tb8, rb8, ti, ri};
  assign irq    = ti | ri;
  assign shift_clk = tx_sclk & rx_sclk;

  always_comb begin
    case (bus_addr)
      ADDR_CTL: bus_rdata = ctl_rd;
      ADDR_DAT: bus_rdata = rbuf;
      ADDR_OPT: bus_rdata = {7'd0, fe_view};
      default:  bus_rdata = 8'd0;
    endcase
  end

  sio_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode),
    .load(dat_wr), .din(bus_wdata), .tb8(tb8),
    .txd(txd), .sdat_o(shift_dout), .sclk_o(tx_sclk),
    .busy(tx_busy), .done_evt(tx_done_evt)
  );

  sio_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .mode(mode),
    .ren(ren), .ri(ri), .sm2(sm2), .rxd(rxd),
    .sclk_o(rx_sclk), .stop_bad(rx_stop_bad), .accept(rx_accept),
    .data(rx_data), .rb8_val(rx_rb8)
  );

  // Software writes first; hardware events below take precedence.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sm0, fe, sm1, sm2, ren, tb8, rb8, ti, ri, fe_view} <= '0;
      rbuf <= '0;
    end else begin
      if (ctl_wr) begin
        if (fe_view) fe <= bus_wdata[7];
        else         sm0 <= bus_wdata[7];
        {sm1, sm2, ren, tb8, rb8, ti, ri} <= bus_wdata[6:0];
      end
      if (opt_wr) fe_view <= bus_wdata[0];
      if (rx_stop_bad) fe <= 1'b1;
      if (tx_done_evt) ti <= 1'b1;
      if (rx_accept) begin
        ri   <= 1'b1;
        rbuf <= rx_data;
        if (mode != MODE_SHIFT) rb8 <= rx_rb8;
      end
    end
  end
endmodule

// File: rtl/sio_fe_uart_chk.sv
module sio_fe_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_wdata,
  input logic       ctl_wr,
  input logic       fe_view,
  input logic       sm0,
  input logic       fe,
  input logic       ti,
  input logic       ri,
  input logic [7:0] rbuf,
  input logic       tx_done_evt,
  input logic       tx_busy,
  input logic       txd,
  input logic       rx_stop_bad,
  input logic       rx_accept
);
  p_fe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop_bad |=> fe);
  p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stop_bad && !ctl_wr) |=> $stable(sm0));
  p_fe_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(ctl_wr && fe_view && !bus_wdata[7])) |=> fe);
  p_ti_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_evt |=> ti);
  p_ri_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> ri);
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ri |=> $stable(rbuf));
  p_ti_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ctl_wr) |=> ti);
  p_ri_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ri && !ctl_wr) |=> ri);
  p_txd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
endmodule

bind sio_fe_uart sio_fe_uart_chk u_chk (.*);

// File: tb/sio_fe_uart_test.sv
module sio_fe_uart_test;
  localparam int OSR = 8;
  localparam int BIT = 2 * OSR;
  localparam logic [1:0] A_CTL = 2'd0, A_DAT = 2'd1, A_OPT = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic rxd = 1'b1;
  logic txd, shift_dout, shift_clk, irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sio_fe_uart #(.OSR(OSR)) uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .shift_dout(shift_dout), .shift_clk(shift_clk), .irq(irq)
  );

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit has9, input logic b9, input logic stopv);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (has9) begin
      rxd = b9;
      repeat (BIT) @(negedge clk);
    end
    rxd = stopv;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic wait_sclk(input logic v);
    @(negedge clk);
    while (shift_clk !== v) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(A_CTL, v); chk("R1 ctl reset", v, 8'h00);
    rd(A_DAT, v); chk("R1 data reset", v, 8'h00);
    rd(A_OPT, v); chk("R1 opt reset", v, 8'h00);
    chk("R1 txd idle", txd, 1);
    chk("R1 shift_clk idle", shift_clk, 1);
    chk("R1 irq low", irq, 0);
  endtask

  task automatic t_view;
    logic [7:0] v;
    wr(A_CTL, 8'h80); rd(A_CTL, v); chk("R2 mode bit view0", v, 8'h80);
    wr(A_OPT, 8'h01); rd(A_CTL, v); chk("R2 flag view1 clear", v, 8'h00);
    wr(A_CTL, 8'h80); rd(A_CTL, v); chk("R2 flag written", v, 8'h80);
    wr(A_OPT, 8'h00); wr(A_CTL, 8'h00); rd(A_CTL, v); chk("R2 mode bit cleared", v, 8'h00);
    wr(A_OPT, 8'h01); rd(A_CTL, v); chk("R2 flag stored apart", v, 8'h80);
    wr(A_CTL, 8'h00); rd(A_CTL, v); chk("R2 flag cleared", v, 8'h00);
    wr(A_OPT, 8'h00);
  endtask

  task automatic t_tx_async(input logic [7:0] cfg, input logic [7:0] d, input bit has9, input logic b9, input string tag);
    logic [7:0] v;
    wr(A_CTL, cfg);
    wr(A_DAT, d);
    repeat (BIT / 2) @(negedge clk);
    chk({tag, " start bit"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      chk({tag, " data bit"}, txd, d[i]);
    end
    if (has9) begin
      repeat (BIT) @(negedge clk);
      chk("R6 ninth bit from TB8", txd, b9);
    end
    chk("R5 TI low before stop", irq, 0);
    repeat (BIT) @(negedge clk);
    chk({tag, " stop bit"}, txd, 1);
    chk("R5 TI at stop start", irq, 1);
    repeat (3 * BIT) @(negedge clk);
    rd(A_CTL, v); chk("R12 TI held", v, {cfg[7:2], 2'b10});
    wr(A_CTL, cfg);
    rd(A_CTL, v); chk("R12 TI cleared", v, cfg);
    chk("R12 irq low after clear", irq, 0);
  endtask

  task automatic t_rx_mode1;
    logic [7:0] v;
    wr(A_CTL, 8'h50);
    rx_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(A_CTL, v); chk("R8 RI set, R6 stop into RB8", v, 8'h55);
    rd(A_DAT, v); chk("R8 data received", v, 8'h5A);
    chk("R12 irq from RI", irq, 1);
    rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
    rd(A_DAT, v); chk("R8 discard when RI set", v, 8'h5A);
    wr(A_CTL, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    rd(A_CTL, v); chk("R7 false start ignored", v, 8'h50);
    rx_frame(8'h33, 1'b0, 1'b0, 1'b1);
    rd(A_DAT, v); chk("R7 receiver recovers", v, 8'h33);
    wr(A_CTL, 8'h50);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    wr(A_CTL, 8'h50);
    rx_frame(8'h77, 1'b0, 1'b0, 1'b0);
    rd(A_CTL, v); chk("R3 mode kept after bad stop", v, 8'h51);
    wr(A_OPT, 8'h01);
    rd(A_CTL, v); chk("R3 error flag set", v, 8'hD1);
    wr(A_OPT, 8'h00);
    wr(A_CTL, 8'h50);
    rx_frame(8'h12, 1'b0, 1'b0, 1'b1);
    rd(A_DAT, v); chk("R4 good frame data", v, 8'h12);
    wr(A_OPT, 8'h01);
    rd(A_CTL, v); chk("R4 flag survives good frame", v, 8'hD5);
    wr(A_CTL, 8'h50);
    rd(A_CTL, v); chk("R4 flag cleared by write 0", v, 8'h50);
    rx_frame(8'h21, 1'b0, 1'b0, 1'b0);
    rd(A_CTL, v); chk("R3 flag set with view1", v, 8'hD1);
    wr(A_CTL, 8'h50);
    wr(A_OPT, 8'h00);
  endtask

  task automatic t_filter;
    logic [7:0] v;
    wr(A_CTL, 8'hF0);
    rx_frame(8'h44, 1'b1, 1'b0, 1'b1);
    rd(A_CTL, v); chk("R9 ninth=0 rejected", v, 8'hF0);
    rx_frame(8'h45, 1'b1, 1'b1, 1'b1);
    rd(A_CTL, v); chk("R9 R6 ninth=1 accepted into RB8", v, 8'hF5);
    rd(A_DAT, v); chk("R9 data", v, 8'h45);
    wr(A_CTL, 8'h70);
    rx_frame(8'h66, 1'b0, 1'b0, 1'b0);
    rd(A_CTL, v); chk("R9 mode1 bad stop rejected", v, 8'h70);
    rd(A_DAT, v); chk("R9 data kept", v, 8'h45);
    wr(A_OPT, 8'h01);
    rd(A_CTL, v); chk("R3 flag set on rejected frame", v, 8'hF0);
    wr(A_CTL, 8'h70);
    wr(A_OPT, 8'h00);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_tx_shift;
    logic [7:0] got;
    logic [7:0] v;
    got = 8'h00;
    wr(A_CTL, 8'h00);
    wr(A_DAT, 8'h96);
    for (int i = 0; i < 8; i++) begin
      wait_sclk(1'b1);
      got[i] = shift_dout;
      if (i < 7) wait_sclk(1'b0);
    end
    chk("R10 shift data", got, 8'h96);
    repeat (8) @(negedge clk);
    rd(A_CTL, v); chk("R10 TI after eighth bit", v, 8'h02);
    chk("R10 shift_clk idle", shift_clk, 1);
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_rx_shift;
    logic [7:0] d;
    logic [7:0] v;
    d = 8'hC3;
    rxd = d[0];
    wr(A_CTL, 8'h10);
    wait_sclk(1'b0);
    for (int i = 0; i < 7; i++) begin
      wait_sclk(1'b1);
      wait_sclk(1'b0);
      rxd = d[i + 1];
    end
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    rd(A_CTL, v); chk("R11 RI after eighth bit", v, 8'h11);
    rd(A_DAT, v); chk("R11 shift data in", v, 8'hC3);
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_view();
    t_tx_async(8'h40, 8'hA5, 1'b0, 1'b0, "R5 mode1");
    t_tx_async(8'hC8, 8'h3C, 1'b1, 1'b1, "R6 mode3");
    t_rx_mode1();
    t_framing();
    t_filter();
    t_tx_shift();
    t_rx_shift();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule